// File: doc/BRIEF.md
# Ternary-Weight Dot-Product Engine

This block forms the inner product of a stream of signed 8-bit activations with a stream of ternary weights, and it does so without a multiplier in the accumulation path. Each weight arrives as a 2-bit code, paired with one activation per valid cycle. The code decides whether the activation is added to the running sum, subtracted from it, or skipped. The running sum lives in a signed accumulator. When the sum would leave the accumulator's range, it clamps to the limit instead of wrapping.

When the last pair of a vector has been taken, the block hands back the sum and pulses a done strobe. It can return the raw sum one cycle later. It can instead apply a per-channel unsigned fixed-point scale, using the only multiplier in the block, and return a rounded result one cycle after that. Two flags travel with every result. One reports that saturation happened during the vector. The other reports that a reserved weight code was seen.

A vector is marked by a first flag on its opening pair and a last flag on its closing pair; a one-pair vector carries both. Cycles with the valid input low may be inserted anywhere and are ignored.

Top module: `tdot_unit`

## Requirements
- R1: Weight code 2'b01 adds the activation to the sum, code 2'b11 subtracts it, and code 2'b00 leaves the sum unchanged.
- R2: A pair with `in_first` set starts the sum from zero and clears both flags, so that pair's contribution alone is the new sum.
- R3: The sum clamps at +2^(ACC_W-1)-1 and -2^(ACC_W-1). Reaching a limit exactly does not set `res_sat`. A step that would cross a limit sets `res_sat`, and the flag stays set until the vector ends.
- R4: Code 2'b10 is reserved. It contributes nothing to the sum and sets `res_err` for that vector.
- R5: A cycle with `in_valid` low changes neither the sum nor the flags, whatever the other inputs carry. Stalls therefore do not alter any result.
- R6: With `scale_en` low at the last pair, `res_valid` is high in the cycle after the clock edge that takes the last pair. `res_data` is then the sign-extended sum.
- R7: With `scale_en` high at the last pair, `res_valid` is high two cycles after that edge. `res_data` is then sum × `alpha` / 2^FRAC, rounded half away from zero. `alpha` is unsigned with FRAC fraction bits and is sampled together with the last pair.
- R8: `res_valid` is a one-cycle pulse per vector, and `res_sat` and `res_err` are valid alongside it.
- R9: During reset and after it, `res_valid` stays low until a vector completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The activation/weight pair is present this cycle |
| in_first | input | 1 | The pair opens a vector |
| in_last | input | 1 | The pair closes a vector |
| in_act | input | ACT_W | Signed activation |
| in_wcode | input | 2 | Ternary weight code: 00 zero, 01 plus one, 11 minus one, 10 reserved |
| scale_en | input | 1 | Apply the scale to this vector; sampled with the last pair |
| alpha | input | SCL_W | Unsigned scale with FRAC fraction bits; sampled with the last pair |
| res_valid | output | 1 | Result pulse |
| res_data | output | ACC_W+SCL_W-FRAC | Signed result |
| res_sat | output | 1 | Saturation happened in this vector |
| res_err | output | 1 | A reserved weight code was seen in this vector |

## Verification
Directed vectors each target one rule in isolation:
- Long runs of +127 and of -128 walk the sum to each limit. One run lands exactly on the negative limit and another goes one step past it, which separates clamping from wrapping and shows when the flag may be raised.
- A vector containing reserved codes shows that they are skipped and that the error flag is set. The vector after it shows that a new first pair clears the flag again.
- Scaled vectors with sums of +3 and -3 at a scale of 1.5 sit on the half-way point from both sides, which separates half-away rounding from truncation and from half-up rounding. Scales of zero and of full range check both ends of the scale.
- One vector is sent twice, once straight and once with junk-filled stalls, and the two results must match.

Seeded random vectors then mix lengths, codes, modes and stalls.

// File: rtl/tdot_pkg.sv
package tdot_pkg;

    // Ternary weight encoding; bit 1 set with bit 0 set means minus one.
    typedef enum logic [1:0] {
        WC_ZERO = 2'b00,
        WC_POS  = 2'b01,
        WC_RSVD = 2'b10,
        WC_NEG  = 2'b11
    } wcode_e;

    // Accumulator action selected by one weight.
    typedef enum logic [1:0] {
        OP_SKIP = 2'b00,
        OP_ADD  = 2'b01,
        OP_SUB  = 2'b10
    } acc_op_e;

endpackage

// File: rtl/tdot_decode.sv
module tdot_decode
    import tdot_pkg::*;
(
    input  logic [1:0] code,
    output acc_op_e    op,
    output logic       bad
);

    always_comb begin
        op  = OP_SKIP;
        bad = 1'b0;
        case (wcode_e'(code))
            WC_POS:  op = OP_ADD;
            WC_NEG:  op = OP_SUB;
            WC_RSVD: bad = 1'b1;
            default: op = OP_SKIP;
        endcase
    end

endmodule

// File: rtl/tdot_accum.sv
module tdot_accum
    import tdot_pkg::*;
#(
    parameter int ACT_W = 8,
    parameter int ACC_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_first,
    input  logic                    in_last,
    input  logic signed [ACT_W-1:0] in_act,
    input  acc_op_e                 op,
    input  logic                    bad,
    output logic signed [ACC_W-1:0] acc,
    output logic                    sat,
    output logic                    err,
    output logic                    done
);

    localparam int XW = ACC_W + 1;
    localparam logic signed [XW-1:0] MAX_X = {2'b00, {(ACC_W-1){1'b1}}};
    localparam logic signed [XW-1:0] MIN_X = {2'b11, {(ACC_W-1){1'b0}}};

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             sat;
        logic             err;
        logic             done;
    } acc_st_t;

    acc_st_t st_d, st_q;

    logic signed [XW-1:0] base_x;
    logic signed [XW-1:0] act_x;
    logic signed [XW-1:0] sum_x;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        base_x    = in_first ? '0 : {st_q.acc[ACC_W-1], st_q.acc};
        act_x     = {{(XW-ACT_W){in_act[ACT_W-1]}}, in_act};
        case (op)
            OP_ADD:  sum_x = base_x + act_x;
            OP_SUB:  sum_x = base_x - act_x;
            default: sum_x = base_x;
        endcase
        if (in_valid) begin
            st_d.sat = in_first ? 1'b0 : st_q.sat;
            st_d.err = (in_first ? 1'b0 : st_q.err) | bad;
            if (sum_x > MAX_X) begin
                st_d.acc = MAX_X[ACC_W-1:0];
                st_d.sat = 1'b1;
            end else if (sum_x < MIN_X) begin
                st_d.acc = MIN_X[ACC_W-1:0];
                st_d.sat = 1'b1;
            end else begin
                st_d.acc = sum_x[ACC_W-1:0];
            end
            st_d.done = in_last;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc  = $signed(st_q.acc);
    assign sat  = st_q.sat;
    assign err  = st_q.err;
    assign done = st_q.done;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(st_q.acc) && $stable(st_q.sat) && $stable(st_q.err))); // R5
    AST_SKIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_first && op == OP_SKIP) |=> $stable(st_q.acc)); // R1
    AST_RSVD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bad) |=> st_q.err); // R4
    AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_first && st_q.sat) |=> st_q.sat); // R3
    AST_DONE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> st_q.done); // R6

endmodule

// File: rtl/tdot_scale.sv
module tdot_scale #(
    parameter int ACC_W = 24,
    parameter int SCL_W = 16,
    parameter int FRAC  = 8,
    localparam int OUT_W = ACC_W + SCL_W - FRAC
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cap,
    input  logic                    mode_in,
    input  logic [SCL_W-1:0]        alpha_in,
    input  logic                    acc_done,
    input  logic signed [ACC_W-1:0] acc_val,
    input  logic                    sat_in,
    input  logic                    err_in,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_data,
    output logic                    out_sat,
    output logic                    out_err
);

    localparam int PW = ACC_W + SCL_W + 1;
    localparam logic [PW-1:0] HALF = PW'(1) << (FRAC - 1);

    typedef struct packed {
        logic             mode;
        logic [SCL_W-1:0] alpha;
        logic             pv;
        logic [OUT_W-1:0] pdata;
        logic             psat;
        logic             perr;
    } scl_st_t;

    scl_st_t st_d, st_q;

    logic signed [PW-1:0] a_x, s_x, prod;
    logic        [PW-1:0] mag, rnd;
    logic signed [PW-1:0] rounded;

    always_comb begin
        st_d    = st_q;
        a_x     = {{(PW-ACC_W){acc_val[ACC_W-1]}}, acc_val};
        s_x     = {{(PW-SCL_W){1'b0}}, st_q.alpha};
        prod    = a_x * s_x;
        mag     = prod[PW-1] ? $unsigned(-prod) : $unsigned(prod);
        rnd     = (mag + HALF) >> FRAC;
        rounded = prod[PW-1] ? -$signed(rnd) : $signed(rnd);
        if (cap) begin
            st_d.mode  = mode_in;
            st_d.alpha = alpha_in;
        end
        st_d.pv = acc_done && st_q.mode;
        if (acc_done && st_q.mode) begin
            st_d.pdata = rounded[OUT_W-1:0];
            st_d.psat  = sat_in;
            st_d.perr  = err_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.pv | (acc_done & ~st_q.mode);
    assign out_data  = st_q.pv ? $signed(st_q.pdata)
                               : {{(OUT_W-ACC_W){acc_val[ACC_W-1]}}, acc_val};
    assign out_sat   = st_q.pv ? st_q.psat : sat_in;
    assign out_err   = st_q.pv ? st_q.perr : err_in;

    AST_SCALED_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_done && st_q.mode) |=> out_valid); // R7
    AST_SCALED_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_done && st_q.mode) |=> (out_sat == $past(sat_in) && out_err == $past(err_in))); // R8

endmodule

// File: rtl/tdot_unit.sv
module tdot_unit
    import tdot_pkg::*;
#(
    parameter int ACT_W = 8,
    parameter int ACC_W = 24,
    parameter int SCL_W = 16,
    parameter int FRAC  = 8,
    localparam int OUT_W = ACC_W + SCL_W - FRAC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_first,
    input  logic             in_last,
    input  logic [ACT_W-1:0] in_act,
    input  logic [1:0]       in_wcode,
    input  logic             scale_en,
    input  logic [SCL_W-1:0] alpha,
    output logic             res_valid,
    output logic [OUT_W-1:0] res_data,
    output logic             res_sat,
    output logic             res_err
);

    acc_op_e                 op;
    logic                    bad;
    logic signed [ACC_W-1:0] acc;
    logic                    sat, err, done;
    logic signed [OUT_W-1:0] data_s;

    tdot_decode u_dec (
        .code (in_wcode),
        .op   (op),
        .bad  (bad)
    );

    tdot_accum #(.ACT_W(ACT_W), .ACC_W(ACC_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_first (in_first),
        .in_last  (in_last),
        .in_act   ($signed(in_act)),
        .op       (op),
        .bad      (bad),
        .acc      (acc),
        .sat      (sat),
        .err      (err),
        .done     (done)
    );

    tdot_scale #(.ACC_W(ACC_W), .SCL_W(SCL_W), .FRAC(FRAC)) u_scl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap       (in_valid & in_last),
        .mode_in   (scale_en),
        .alpha_in  (alpha),
        .acc_done  (done),
        .acc_val   (acc),
        .sat_in    (sat),
        .err_in    (err),
        .out_valid (res_valid),
        .out_data  (data_s),
        .out_sat   (res_sat),
        .out_err   (res_err)
    );

    assign res_data = data_s;

    AST_RESULT_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last && !scale_en) |=> res_valid); // R6

endmodule

// File: tb/tdot_unit_test.sv
module tdot_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int ACT_W = 8;
    localparam int ACC_W = 14;
    localparam int SCL_W = 16;
    localparam int FRAC  = 8;
    localparam int OUT_W = ACC_W + SCL_W - FRAC;
    localparam longint LIM_HI = (longint'(1) <<< (ACC_W-1)) - 1;
    localparam longint LIM_LO = -(longint'(1) <<< (ACC_W-1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
    logic [ACT_W-1:0] in_act = '0;
    logic [1:0] in_wcode = '0;
    logic scale_en = 1'b0;
    logic [SCL_W-1:0] alpha = '0;
    logic res_valid;
    logic [OUT_W-1:0] res_data;
    logic res_sat, res_err;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic signed [ACT_W-1:0] v_act [0:127];
    logic [1:0] v_code [0:127];
    int v_len;

    tdot_unit #(.ACT_W(ACT_W), .ACC_W(ACC_W), .SCL_W(SCL_W), .FRAC(FRAC)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .in_last(in_last), .in_act(in_act), .in_wcode(in_wcode),
        .scale_en(scale_en), .alpha(alpha), .res_valid(res_valid),
        .res_data(res_data), .res_sat(res_sat), .res_err(res_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model of the sum and flags from the requirements.
    task automatic model(output longint s, output bit st, output bit er);
        s = 0; st = 0; er = 0;
        for (int i = 0; i < v_len; i++) begin
            longint a = longint'(v_act[i]);
            case (v_code[i])
                2'b01: s = s + a;
                2'b11: s = s - a;
                2'b10: er = 1;
                default: ;
            endcase
            if (s > LIM_HI) begin s = LIM_HI; st = 1; end
            if (s < LIM_LO) begin s = LIM_LO; st = 1; end
        end
    endtask

    function automatic longint scl(input longint s, input longint al);
        longint p = s * al;
        longint h = longint'(1) <<< (FRAC-1);
        if (p < 0) return -(((-p) + h) >>> FRAC);
        return (p + h) >>> FRAC;
    endfunction

    task automatic idle_junk();
        in_valid = 1'b0;
        in_first = 1'($urandom);
        in_last  = 1'($urandom);
        in_act   = ACT_W'($urandom);
        in_wcode = 2'($urandom);
    endtask

    task automatic send(input bit mode, input logic [SCL_W-1:0] al, input int stall_pct, input string req);
        longint es, exp_d;
        bit est, eer;
        model(es, est, eer);
        exp_d = mode ? scl(es, longint'(al)) : es;
        for (int i = 0; i < v_len; i++) begin
            if (int'($urandom_range(99)) < stall_pct) begin
                idle_junk();
                repeat ($urandom_range(3, 1)) @(negedge clk);
            end
            in_valid = 1'b1;
            in_first = (i == 0);
            in_last  = (i == v_len - 1);
            in_act   = v_act[i];
            in_wcode = v_code[i];
            scale_en = (i == v_len - 1) ? mode : 1'($urandom);
            alpha    = (i == v_len - 1) ? al : SCL_W'($urandom);
            @(negedge clk);
        end
        idle_junk();
        if (mode) begin
            chk(res_valid == 1'b0, {req, " R7 early valid"}, res_valid, 0);
            @(negedge clk);
        end
        chk(res_valid == 1'b1, {req, mode ? " R7 valid" : " R6 valid"}, res_valid, 1);
        chk(longint'($signed(res_data)) == exp_d, {req, mode ? " R7 data" : " R6 data"},
            longint'($signed(res_data)), exp_d);
        chk(res_sat == est, {req, " R3 sat"}, res_sat, est);
        chk(res_err == eer, {req, " R4 err"}, res_err, eer);
        @(negedge clk);
        chk(res_valid == 1'b0, {req, " R8 pulse"}, res_valid, 0);
    endtask

    task automatic fill(input int n, input int a, input logic [1:0] c);
        v_len = n;
        for (int i = 0; i < n; i++) begin
            v_act[i] = ACT_W'(a);
            v_code[i] = c;
        end
    endtask

    initial begin
        int guard = 0;
        while (!finished) begin
            @(posedge clk);
            guard++;
            if (guard > 150000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=hang expected=finish");
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        chk(res_valid == 1'b0, "R9 reset", res_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(res_valid == 1'b0, "R9 after reset", res_valid, 0);

        // R1 mixed codes
        v_len = 6;
        v_act[0] = 8'sd10;  v_code[0] = 2'b01;
        v_act[1] = 8'sd3;   v_code[1] = 2'b11;
        v_act[2] = 8'sd99;  v_code[2] = 2'b00;
        v_act[3] = -8'sd20; v_code[3] = 2'b01;
        v_act[4] = -8'sd7;  v_code[4] = 2'b11;
        v_act[5] = 8'sd1;   v_code[5] = 2'b01;
        send(1'b0, 16'h0100, 0, "R1 mix");

        // R2 single pair after nonzero sum
        fill(1, 5, 2'b01);
        send(1'b0, 16'h0100, 0, "R2 single");

        // R3 limits
        fill(80, 127, 2'b01);
        send(1'b0, 16'h0100, 0, "R3 pos clamp");
        fill(64, -128, 2'b01);
        send(1'b0, 16'h0100, 0, "R3 exact low");
        fill(65, -128, 2'b01);
        send(1'b0, 16'h0100, 0, "R3 past low");
        fill(70, -128, 2'b11);
        send(1'b0, 16'h0100, 0, "R3 sub clamp");

        // R4 reserved codes, then clean vector
        fill(4, 50, 2'b10);
        v_act[2] = 8'sd7; v_code[2] = 2'b01;
        send(1'b0, 16'h0100, 0, "R4 reserved");
        fill(2, 9, 2'b11);
        send(1'b0, 16'h0100, 0, "R4 cleared R2");

        // R7 scaling and rounding
        fill(1, 3, 2'b01);
        send(1'b1, 16'h0180, 0, "R7 half pos");
        fill(1, 3, 2'b11);
        send(1'b1, 16'h0180, 0, "R7 half neg");
        fill(5, 77, 2'b01);
        send(1'b1, 16'h0000, 0, "R7 zero scale");
        fill(80, 127, 2'b01);
        send(1'b1, 16'hFFFF, 0, "R7 max scale");
        fill(70, 127, 2'b11);
        send(1'b1, 16'hFFFF, 0, "R7 min scale");

        // R5 same vector with and without stalls
        v_len = 20;
        for (int i = 0; i < 20; i++) begin
            v_act[i] = ACT_W'($urandom);
            v_code[i] = 2'($urandom);
        end
        send(1'b1, 16'h0233, 0, "R5 plain");
        send(1'b1, 16'h0233, 60, "R5 stalled");

        // Random mix
        for (int k = 0; k < 60; k++) begin
            v_len = int'($urandom_range(40, 1));
            for (int i = 0; i < v_len; i++) begin
                v_act[i] = ACT_W'($urandom);
                v_code[i] = 2'($urandom);
            end
            send(1'($urandom), SCL_W'($urandom), 25, "R1 rand");
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule